// File: doc/BRIEF.md
# Pipelined Serial ADC Channel Scanner

This block sits on the host side of a full-duplex serial link to a nine-input analog-to-digital converter and keeps the converter busy without software help. Each frame is 16 serial clocks with chip select held low throughout. The block sends the number of the next channel to convert and, in the same frame, takes in the result of the channel it named in the frame before. The returned word is realigned and offered on a valid/ready output, tagged with the channel it belongs to.

Between frames the block waits for the converter to finish. In counting mode it generates a free-running converter clock and lets at least a fixed number of its cycles pass. In handshake mode it waits for the converter's end-of-conversion line to go high. Channels are visited in ascending order and wrap from the last back to zero. The first frame after the scan is enabled returns a result that belongs to no requested channel, so it is thrown away. A frame can also be split into two bytes with an idle stretch of serial clock between them.

If the consumer stops taking results, the scan stops at the next frame boundary and drops nothing. Dropping the enable lets the current frame and its conversion wait complete and then stops. Raising it again starts the scan over from channel zero.

Top module: `adc_scan_ctrl`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `cs_n` is 1, `sclk` is 0, `mosi` is 0 and `out_valid` is 0.
- R2: A frame keeps `cs_n` low for exactly 16 rising edges of `sclk`. `sclk` rests low whenever `cs_n` is high. `mosi` changes after falling edges and is sampled on rising edges. The first 4 bits sent, MSB first, are the channel number, and the last 12 bits sent are 0.
- R3: The channel numbers sent go 0, 1, … 8 and then wrap back to 0. `out_chan` never exceeds 8.
- R4: `out_data` equals the first 10 bits received in a frame, MSB first, right-justified. The 6 bits received after them have no effect, whatever their value.
- R5: Each output word is tagged with the channel number sent in the frame before the one that returned it.
- R6: After enable, the first frame produces no output. The first output appears once the second frame ends, and it carries channel 0.
- R7: With `eoc_mode`=0, at least 44 rising edges of `adc_clk` occur between the end of one frame and the start of the next. The level of `eoc` has no effect.
- R8: With `eoc_mode`=1, a frame starts only after `eoc` has been seen high since the previous frame ended.
- R9: With `byte_gap`=0, consecutive `sclk` rising edges inside a frame are 2·CLK_DIV clocks apart. With `byte_gap`=1, the gap between the 8th and 9th rising edge is 2·CLK_DIV+GAP_CYC clocks and every other gap is unchanged.
- R10: While `out_valid`=1 and `out_ready`=0, `out_valid`, `out_chan` and `out_data` hold and no frame starts. The sequence of results resumes with no channel missing.
- R11: With `en` low, no new frame starts once the frame in progress and its wait have finished. Raising `en` again restarts the scan at channel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Scan enable |
| eoc_mode | input | 1 | 0: count converter clocks between frames; 1: wait for `eoc` |
| byte_gap | input | 1 | 1: insert an idle stretch between the two bytes of a frame |
| sclk | output | 1 | Serial clock to the converter, idles low |
| cs_n | output | 1 | Active-low chip select, low for a whole frame |
| mosi | output | 1 | Serial data to the converter (channel number) |
| miso | input | 1 | Serial data from the converter (result) |
| eoc | input | 1 | End-of-conversion from the converter |
| adc_clk | output | 1 | Free-running conversion clock for the converter |
| out_ready | input | 1 | Consumer accepts the output word |
| out_valid | output | 1 | Output word is valid |
| out_chan | output | 4 | Channel the result belongs to |
| out_data | output | 10 | Right-justified conversion result |

## Verification
The assertions assume that `eoc_mode` and `byte_gap` stay constant while a scan is running. They also assume that the converter pulls `eoc` low when a frame begins and raises it only once its conversion is done, and that `miso` changes only after falling edges of `sclk`. The bench's converter model follows exactly that discipline: it shifts its result out after each falling edge, pads it with ones, and holds `eoc` low from chip-select fall until a set delay after chip-select rise. Modes are changed only after `en` has been low long enough for the block to go idle, while `out_ready` is taken low for a long stretch to exercise the stall.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

  // Frame geometry shared by the scanner pieces
  parameter int FRAME_BITS = 16;
  parameter int CHAN_BITS  = 4;
  parameter int CODE_BITS  = 10;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_START = 2'd1,
    SQ_XFER  = 2'd2,
    SQ_WAIT  = 2'd3
  } seq_state_t;

endpackage

// File: rtl/adc_scan_shifter.sv
// Full-duplex frame engine: drives chip select and the serial clock, shifts
// the outgoing word MSB first and samples the incoming word on rising edges.
module adc_scan_shifter #(
  parameter int FRAME_W  = 16,
  parameter int RES_W    = 10,
  parameter int CLK_DIV  = 2,
  parameter int GAP_CYC  = 6,
  parameter int SPLIT_AT = FRAME_W / 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               byte_gap,
  input  logic [FRAME_W-1:0] tx_word,
  input  logic               miso,
  output logic               sclk,
  output logic               cs_n,
  output logic               mosi,
  output logic               done,
  output logic [RES_W-1:0]   rx_res
);

  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int BIT_W = $clog2(FRAME_W + 1);
  localparam int GAP_W = $clog2(GAP_CYC + 2);

  logic               busy;
  logic [DIV_W-1:0]   div_cnt;
  logic [BIT_W-1:0]   bit_idx;
  logic [GAP_W-1:0]   gap_cnt;
  logic [FRAME_W-1:0] tx_sr;
  logic [FRAME_W-1:0] rx_sr;
  logic               tick;
  logic               gap_hold;
  logic               split_pt;
  logic               last_bit;

  // Optional idle stretch between the two bytes
  generate
    if (GAP_CYC > 0) begin : g_gap
      assign gap_hold = (gap_cnt != '0);
      assign split_pt = byte_gap && (bit_idx == BIT_W'(SPLIT_AT - 1));
    end else begin : g_nogap
      assign gap_hold = 1'b0;
      assign split_pt = 1'b0;
    end
  endgenerate

  assign tick     = busy && !gap_hold && (div_cnt == DIV_W'(CLK_DIV - 1));
  assign last_bit = (bit_idx == BIT_W'(FRAME_W - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      cs_n    <= 1'b1;
      sclk    <= 1'b0;
      div_cnt <= '0;
      bit_idx <= '0;
      gap_cnt <= '0;
      tx_sr   <= '0;
      rx_sr   <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy    <= 1'b1;
          cs_n    <= 1'b0;
          sclk    <= 1'b0;
          div_cnt <= '0;
          bit_idx <= '0;
          gap_cnt <= '0;
          tx_sr   <= tx_word;
        end
      end else if (gap_hold) begin
        gap_cnt <= gap_cnt - 1'b1;
      end else if (!tick) begin
        div_cnt <= div_cnt + 1'b1;
      end else begin
        div_cnt <= '0;
        if (!sclk) begin
          sclk  <= 1'b1;
          rx_sr <= {rx_sr[FRAME_W-2:0], miso};
        end else begin
          sclk    <= 1'b0;
          tx_sr   <= {tx_sr[FRAME_W-2:0], 1'b0};
          bit_idx <= bit_idx + 1'b1;
          if (last_bit) begin
            busy <= 1'b0;
            cs_n <= 1'b1;
            done <= 1'b1;
          end else if (split_pt) begin
            gap_cnt <= GAP_W'(GAP_CYC);
          end
        end
      end
    end
  end

  assign mosi   = tx_sr[FRAME_W-1];
  assign rx_res = rx_sr[FRAME_W-1 -: RES_W];

endmodule

// File: rtl/adc_scan_wait.sv
// Conversion wait: either counts rising edges of a generated converter
// clock, or waits for a synchronised end-of-conversion level.
module adc_scan_wait #(
  parameter int CONV_CYCLES = 44,
  parameter int ADC_HALF    = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic eoc_mode,
  input  logic eoc,
  output logic adc_clk,
  output logic done
);

  localparam int HDIV_W = (ADC_HALF > 1) ? $clog2(ADC_HALF) : 1;
  localparam int CNT_W  = $clog2(CONV_CYCLES + 1);

  logic [HDIV_W-1:0] hdiv;
  logic [CNT_W-1:0]  conv_cnt;
  logic [1:0]        eoc_sync;
  logic              active;
  logic              half_end;
  logic              adc_rise;
  logic              count_end;

  assign half_end  = (hdiv == HDIV_W'(ADC_HALF - 1));
  assign adc_rise  = half_end && !adc_clk;
  assign count_end = (conv_cnt == CNT_W'(CONV_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      hdiv     <= '0;
      adc_clk  <= 1'b0;
      eoc_sync <= '0;
    end else begin
      eoc_sync <= {eoc_sync[0], eoc};
      if (half_end) begin
        hdiv    <= '0;
        adc_clk <= ~adc_clk;
      end else begin
        hdiv <= hdiv + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      conv_cnt <= '0;
      active   <= 1'b0;
      done     <= 1'b0;
    end else if (arm) begin
      conv_cnt <= '0;
      active   <= 1'b1;
      done     <= 1'b0;
    end else if (active) begin
      if (eoc_mode) begin
        if (eoc_sync[1]) begin
          active <= 1'b0;
          done   <= 1'b1;
        end
      end else if (adc_rise) begin
        conv_cnt <= conv_cnt + 1'b1;
        if (count_end) begin
          active <= 1'b0;
          done   <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/adc_scan_seq.sv
// Scan sequencer: channel order, one-deep channel pipeline, first-frame
// discard, and the registered output word under valid/ready.
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int NUM_CH  = 9,
  parameter int ADDR_W  = 4,
  parameter int RES_W   = 10,
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic               shift_done,
  input  logic [RES_W-1:0]   rx_res,
  input  logic               wait_done,
  input  logic               out_ready,
  output logic               start,
  output logic [FRAME_W-1:0] tx_word,
  output logic               arm,
  output logic               out_valid,
  output logic [ADDR_W-1:0]  out_chan,
  output logic [RES_W-1:0]   out_data
);

  localparam int TAIL_W = FRAME_W - ADDR_W;

  seq_state_t        state_q;
  logic [ADDR_W-1:0] chan_q;
  logic [ADDR_W-1:0] tag_q;
  logic              primed_q;
  logic [ADDR_W-1:0] chan_nx;

  assign chan_nx = (chan_q == ADDR_W'(NUM_CH - 1)) ? '0 : chan_q + 1'b1;
  assign start   = (state_q == SQ_START) && en && !out_valid;
  assign tx_word = {chan_q, {TAIL_W{1'b0}}};
  assign arm     = (state_q == SQ_XFER) && shift_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= SQ_IDLE;
      chan_q    <= '0;
      tag_q     <= '0;
      primed_q  <= 1'b0;
      out_valid <= 1'b0;
      out_chan  <= '0;
      out_data  <= '0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      case (state_q)
        SQ_IDLE: begin
          if (en) begin
            chan_q   <= '0;
            primed_q <= 1'b0;
            state_q  <= SQ_START;
          end
        end
        SQ_START: begin
          if (!en)             state_q <= SQ_IDLE;
          else if (!out_valid) state_q <= SQ_XFER;
        end
        SQ_XFER: begin
          if (shift_done) begin
            if (primed_q) begin
              out_valid <= 1'b1;
              out_chan  <= tag_q;
              out_data  <= rx_res;
            end
            tag_q    <= chan_q;
            primed_q <= 1'b1;
            chan_q   <= chan_nx;
            state_q  <= SQ_WAIT;
          end
        end
        default: begin
          if (wait_done) state_q <= SQ_START;
        end
      endcase
    end
  end

endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
  import adc_scan_pkg::*;
#(
  parameter int NUM_CH      = 9,
  parameter int ADDR_W      = CHAN_BITS,
  parameter int RES_W       = CODE_BITS,
  parameter int FRAME_W     = FRAME_BITS,
  parameter int CLK_DIV     = 2,
  parameter int GAP_CYC     = 6,
  parameter int ADC_HALF    = 2,
  parameter int CONV_CYCLES = 44
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              eoc_mode,
  input  logic              byte_gap,
  output logic              sclk,
  output logic              cs_n,
  output logic              mosi,
  input  logic              miso,
  input  logic              eoc,
  output logic              adc_clk,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_chan,
  output logic [RES_W-1:0]  out_data
);

  logic               start;
  logic               arm;
  logic               shift_done;
  logic               wait_done;
  logic [FRAME_W-1:0] tx_word;
  logic [RES_W-1:0]   rx_res;

  adc_scan_seq #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W),
    .RES_W  (RES_W),
    .FRAME_W(FRAME_W)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .shift_done(shift_done),
    .rx_res    (rx_res),
    .wait_done (wait_done),
    .out_ready (out_ready),
    .start     (start),
    .tx_word   (tx_word),
    .arm       (arm),
    .out_valid (out_valid),
    .out_chan  (out_chan),
    .out_data  (out_data)
  );

  adc_scan_shifter #(
    .FRAME_W(FRAME_W),
    .RES_W  (RES_W),
    .CLK_DIV(CLK_DIV),
    .GAP_CYC(GAP_CYC)
  ) u_shift (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .byte_gap(byte_gap),
    .tx_word (tx_word),
    .miso    (miso),
    .sclk    (sclk),
    .cs_n    (cs_n),
    .mosi    (mosi),
    .done    (shift_done),
    .rx_res  (rx_res)
  );

  adc_scan_wait #(
    .CONV_CYCLES(CONV_CYCLES),
    .ADC_HALF   (ADC_HALF)
  ) u_wait (
    .clk     (clk),
    .rst     (rst),
    .arm     (arm),
    .eoc_mode(eoc_mode),
    .eoc     (eoc),
    .adc_clk (adc_clk),
    .done    (wait_done)
  );

endmodule

// File: rtl/adc_scan_ctrl_chk.sv
module adc_scan_ctrl_chk #(
  parameter int ADDR_W      = 4,
  parameter int RES_W       = 10,
  parameter int NUM_CH      = 9,
  parameter int CONV_CYCLES = 44
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic              eoc_mode,
  input logic              sclk,
  input logic              cs_n,
  input logic              mosi,
  input logic              eoc,
  input logic              adc_clk,
  input logic              out_ready,
  input logic              out_valid,
  input logic [ADDR_W-1:0] out_chan,
  input logic [RES_W-1:0]  out_data
);

  logic        sclk_d;
  logic        adc_d;
  logic [4:0]  fall_cnt;
  logic [15:0] rise_cnt;
  logic        eoc_hi;
  logic        seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d   <= 1'b0;
      adc_d    <= 1'b0;
      fall_cnt <= '0;
      rise_cnt <= '0;
      eoc_hi   <= 1'b0;
      seen     <= 1'b0;
    end else begin
      sclk_d <= sclk;
      adc_d  <= adc_clk;
      if (cs_n) fall_cnt <= '0;
      else if (sclk_d && !sclk && fall_cnt != 5'h1F) fall_cnt <= fall_cnt + 1'b1;
      if (!cs_n) rise_cnt <= '0;
      else if (!adc_d && adc_clk && rise_cnt != 16'hFFFF) rise_cnt <= rise_cnt + 1'b1;
      if (!cs_n) eoc_hi <= 1'b0;
      else if (eoc) eoc_hi <= 1'b1;
      if (!en) seen <= 1'b0;
      else if (!cs_n) seen <= 1'b1;
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (cs_n && !sclk && !mosi && !out_valid));

  // R2
  sclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sclk);

  // R2
  pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && fall_cnt >= 5'd4) |-> !mosi);

  // R3
  chan_range_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_chan <= ADDR_W'(NUM_CH - 1)));

  // R10
  hold_word_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_chan) && $stable(out_data)));

  // R10
  no_frame_pending_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> cs_n);

  // R7
  conv_count_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(cs_n) && seen && !eoc_mode) |-> (rise_cnt >= 16'(CONV_CYCLES)));

  // R8
  eoc_wait_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(cs_n) && seen && eoc_mode) |-> eoc_hi);

endmodule

bind adc_scan_ctrl adc_scan_ctrl_chk #(
  .ADDR_W     (ADDR_W),
  .RES_W      (RES_W),
  .NUM_CH     (NUM_CH),
  .CONV_CYCLES(CONV_CYCLES)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .en       (en),
  .eoc_mode (eoc_mode),
  .sclk     (sclk),
  .cs_n     (cs_n),
  .mosi     (mosi),
  .eoc      (eoc),
  .adc_clk  (adc_clk),
  .out_ready(out_ready),
  .out_valid(out_valid),
  .out_chan (out_chan),
  .out_data (out_data)
);

// File: tb/adc_scan_ctrl_test.sv
module adc_scan_ctrl_test;

  localparam int CLK_DIV = 2;
  localparam int GAP_CYC = 6;
  localparam int EOC_DLY = 300;
  localparam int NCH     = 9;

  // {channel, converter code}
  localparam logic [13:0] VEC [NCH] = '{
    {4'd0, 10'h000}, {4'd1, 10'h3FF}, {4'd2, 10'h200},
    {4'd3, 10'h001}, {4'd4, 10'h155}, {4'd5, 10'h2AA},
    {4'd6, 10'h0F0}, {4'd7, 10'h30C}, {4'd8, 10'h1E7}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic eoc_mode = 1'b0;
  logic byte_gap = 1'b0;
  logic miso = 1'b0;
  logic eoc = 1'b0;
  logic out_ready = 1'b1;
  logic sclk, cs_n, mosi, adc_clk, out_valid;
  logic [3:0] out_chan;
  logic [9:0] out_data;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  adc_scan_ctrl uut (
    .clk(clk), .rst(rst), .en(en), .eoc_mode(eoc_mode), .byte_gap(byte_gap),
    .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso), .eoc(eoc),
    .adc_clk(adc_clk), .out_ready(out_ready), .out_valid(out_valid),
    .out_chan(out_chan), .out_data(out_data)
  );

  // Converter model and link monitors
  logic        eoc_force_low = 1'b1;
  logic [9:0]  mask = 10'h000;
  logic        prev_cs = 1'b1, prev_sclk = 1'b0, prev_adc = 1'b0;
  logic [15:0] m_sr = 16'h0, m_rx = 16'h0, next_sr = 16'h0;
  int cyc = 0, m_rises = 0, last_rise = 0, end_cyc = 0, eoc_timer = 0;
  int frame_bad = 0, int_bad = 0, gap_int = 0, falls = 0;
  int idle_rises = 0, min_rises = 1000000, min_idle = 1000000;
  logic idle_ok = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (!en) idle_ok = 1'b0;
    if (cs_n && !prev_adc && adc_clk) idle_rises++;
    if (prev_cs && !cs_n) begin
      falls++;
      if (idle_ok) begin
        if (idle_rises < min_rises) min_rises = idle_rises;
        if (cyc - end_cyc < min_idle) min_idle = cyc - end_cyc;
      end
      m_sr = next_sr;
      miso = m_sr[15];
      m_rx = 16'h0;
      m_rises = 0;
    end
    if (!cs_n && !prev_sclk && sclk) begin
      m_rx = {m_rx[14:0], mosi};
      m_rises++;
      if (m_rises == 9) gap_int = cyc - last_rise;
      if (m_rises > 1) begin
        if (m_rises == 9 && byte_gap) begin
          if (cyc - last_rise != 2*CLK_DIV + GAP_CYC) int_bad++;
        end else if (cyc - last_rise != 2*CLK_DIV) int_bad++;
      end
      last_rise = cyc;
    end
    if (!cs_n && prev_sclk && !sclk) begin
      m_sr = {m_sr[14:0], 1'b0};
      miso = m_sr[15];
    end
    if (!prev_cs && cs_n) begin
      if (m_rises != 16 || m_rx[11:0] != 12'h0 || m_rx[15:12] > 4'd8) frame_bad++;
      if (m_rx[15:12] <= 4'd8)
        next_sr = {VEC[m_rx[15:12]][9:0] ^ mask, 6'h3F};
      else
        next_sr = 16'h0;
      end_cyc = cyc;
      idle_rises = 0;
      eoc_timer = EOC_DLY;
      idle_ok = en;
    end
    if (eoc_force_low || !cs_n) eoc = 1'b0;
    else if (eoc_timer > 0) begin eoc_timer--; eoc = 1'b0; end
    else eoc = 1'b1;
    prev_cs = cs_n;
    prev_sclk = sclk;
    prev_adc = adc_clk;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic get_out(output logic [3:0] c, output logic [9:0] d);
    @(negedge clk);
    while (!(out_valid && out_ready)) @(negedge clk);
    c = out_chan;
    d = out_data;
    @(posedge clk);
  endtask

  task automatic go_idle();
    @(negedge clk);
    en = 1'b0;
    repeat (1500) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [3:0] c;
    logic [9:0] d;
    int base, ch, k0, stall_bad;

    // R1 reset state
    repeat (4) @(negedge clk);
    chk(cs_n == 1'b1, "R1 cs_n", int'(cs_n), 1);
    chk(sclk == 1'b0, "R1 sclk", int'(sclk), 0);
    chk(mosi == 1'b0, "R1 mosi", int'(mosi), 0);
    chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // Phase 1: count mode, continuous frames, eoc held low (R7 ignores it)
    base = falls;
    en = 1'b1;
    for (int k = 0; k < 20; k++) begin
      get_out(c, d);
      ch = k % NCH;
      if (k == 0) chk(falls - base == 2, "R6 frames before first output", falls - base, 2);
      chk(c == VEC[ch][13:10], "R3 R5 channel order", int'(c), int'(VEC[ch][13:10]));
      chk(d == VEC[ch][9:0], "R4 result", int'(d), int'(VEC[ch][9:0]));
    end
    go_idle();
    base = falls;
    repeat (500) @(negedge clk);
    chk(falls == base, "R11 no frame while disabled", falls - base, 0);
    chk(frame_bad == 0, "R2 frame format", frame_bad, 0);
    chk(int_bad == 0, "R9 clock spacing without gap", int_bad, 0);
    chk(gap_int == 2*CLK_DIV, "R9 mid-frame spacing", gap_int, 2*CLK_DIV);
    chk(min_rises >= 44, "R7 converter clocks between frames", min_rises, 44);

    // Phase 2: eoc handshake, split bytes, inverted codes
    eoc_force_low = 1'b0;
    eoc_mode = 1'b1;
    byte_gap = 1'b1;
    mask = 10'h3FF;
    min_idle = 1000000;
    base = falls;
    @(negedge clk);
    en = 1'b1;
    k0 = 0;
    for (int k = 0; k < 12; k++) begin
      ch = k % NCH;
      if (k == 4) begin
        // R10 stall: hold ready low while a word is pending
        out_ready = 1'b0;
        @(negedge clk);
        while (!out_valid) @(negedge clk);
        c = out_chan;
        d = out_data;
        stall_bad = 0;
        for (int t = 0; t < 600; t++) begin
          @(negedge clk);
          if (!out_valid || out_chan != c || out_data != d || !cs_n) stall_bad++;
        end
        chk(stall_bad == 0, "R10 stall holds word and scan", stall_bad, 0);
        out_ready = 1'b1;
      end
      get_out(c, d);
      if (k == 0) begin
        chk(falls - base == 2, "R6 R11 restart discards first frame", falls - base, 2);
        chk(c == 4'd0, "R11 restart at channel 0", int'(c), 0);
      end
      chk(c == VEC[ch][13:10], "R3 R5 R10 channel sequence", int'(c), int'(VEC[ch][13:10]));
      chk(d == (VEC[ch][9:0] ^ 10'h3FF), "R4 result", int'(d), int'(VEC[ch][9:0] ^ 10'h3FF));
      k0++;
    end
    go_idle();
    chk(frame_bad == 0, "R2 frame format split", frame_bad, 0);
    chk(int_bad == 0, "R9 clock spacing with gap", int_bad, 0);
    chk(gap_int == 2*CLK_DIV + GAP_CYC, "R9 byte gap length", gap_int, 2*CLK_DIV + GAP_CYC);
    chk(min_idle >= EOC_DLY, "R8 frame waits for eoc", min_idle, EOC_DLY);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule